// File: doc/BRIEF.md
# Entropy Refresh Controller for a Masked Hash Engine

This block decides when a masked hashing engine needs fresh randomness and fetches it from an external entropy source. Three events cause a refresh: a start command, the completion of a hash operation, and the expiry of a programmable countdown timer. Each event raises a level request toward the entropy source. The request holds until the source acknowledges it with a data word. The word is then registered and presented to the engine's randomness register with a single-cycle valid strobe.

The countdown timer reloads its programmed value on every accepted acknowledge. It is inactive when its enable is low or its programmed value is zero. Events that arrive while a request is already outstanding are folded into that request, so one acknowledge satisfies them all. A programmable wait limit raises an error pulse if the source takes too long to answer; a limit of zero turns this check off. The whole block, timer included, sits in the entropy source's reset domain.

Top module: `entropy_refresh_ctrl`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `req_o`, `rand_valid_o` and `timeout_err_o` are 0 and `rand_o` is all zeros.
- R2: A cycle with `start_i` high and no request outstanding makes `req_o` high from the next cycle. `req_o` then stays high until a cycle in which `ack_i` is high.
- R3: A cycle with `done_i` high and no request outstanding makes `req_o` high from the next cycle.
- R4: With `timer_en_i` high and `timer_load_i` = N > 0, a handshake (`req_o` and `ack_i` both high) on clock edge E loads the timer. If nothing else intervenes, `req_o` then rises after edge E+N.
- R5: With `timer_en_i` low, or with `timer_load_i` zero, the timer never raises a request.
- R6: While `req_o` is high, further start, done or timer events create no extra request. `req_o` is low on the cycle after the handshake, even if an event coincides with the handshake cycle.
- R7: A handshake on edge E latches `data_i` into `rand_o` and drives `rand_valid_o` high for exactly the cycle after E. `rand_o` keeps that value until the next handshake.
- R8: With `wait_limit_i` = L > 0, a request unanswered for L cycles produces a one-cycle `timeout_err_o` pulse after edge L of waiting, and the request stays pending. With L = 0, no error is ever raised.
- R9: Asserting reset clears the running timer. After release, no timer request occurs until a new handshake reloads it.
- R10: `ack_i` while `req_o` is low is ignored: no valid strobe is produced and `rand_o` is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset of the entropy domain |
| start_i | input | 1 | Start-command strobe |
| done_i | input | 1 | Hash-complete strobe |
| timer_load_i | input | TIMER_W | Refresh period in cycles; 0 disables the timer |
| timer_en_i | input | 1 | Refresh timer enable |
| wait_limit_i | input | WAIT_W | Acknowledge wait limit in cycles; 0 disables the check |
| req_o | output | 1 | Entropy request, held until acknowledged |
| ack_i | input | 1 | Entropy acknowledge |
| data_i | input | DATA_W | Entropy word, valid with `ack_i` |
| rand_o | output | DATA_W | Registered entropy for the engine |
| rand_valid_o | output | 1 | One-cycle strobe marking a new `rand_o` |
| timeout_err_o | output | 1 | One-cycle pulse when the wait limit is reached |

## Verification
A per-cycle table with the timer off drives lone start and done strobes, coincident start and done, triggers stacked on a pending request, triggers on the same cycle as the handshake, and an acknowledge with no request pending. Together these separate real request creation from merging and from spurious data capture. Directed runs then measure the exact cycle of the timer request for a long period and for a period of one. They show that a zero period or a cleared enable stays silent, and that a mid-count reset kills the countdown. They also locate the timeout pulse at its precise cycle and confirm that a zero limit never fires.

// File: rtl/entropy_refresh_ctrl.sv
module entropy_refresh_ctrl #(
  parameter int TIMER_W = 16,
  parameter int DATA_W  = 32,
  parameter int WAIT_W  = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               done_i,
  input  logic [TIMER_W-1:0] timer_load_i,
  input  logic               timer_en_i,
  input  logic [WAIT_W-1:0]  wait_limit_i,
  output logic               req_o,
  input  logic               ack_i,
  input  logic [DATA_W-1:0]  data_i,
  output logic [DATA_W-1:0]  rand_o,
  output logic               rand_valid_o,
  output logic               timeout_err_o
);

  localparam logic [TIMER_W-1:0] TMR_ONE  = TIMER_W'(1);
  localparam logic [WAIT_W-1:0]  WAIT_ONE = WAIT_W'(1);
  localparam logic [WAIT_W-1:0]  WAIT_MAX = '1;

  logic [TIMER_W-1:0] tmr_q;
  logic [WAIT_W-1:0]  wait_q;
  logic handshake, tmr_on, tmr_fire, trigger, waiting, limit_hit;

  assign handshake = req_o & ack_i;
  assign tmr_on    = timer_en_i & (timer_load_i != '0);
  assign tmr_fire  = tmr_on & (tmr_q == TMR_ONE) & ~handshake;
  assign trigger   = start_i | done_i | tmr_fire;
  assign waiting   = req_o & ~ack_i;
  assign limit_hit = (wait_limit_i != '0) & (wait_q == wait_limit_i - WAIT_ONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              tmr_q <= '0;
    else if (handshake)       tmr_q <= timer_load_i;
    else if (!tmr_on)         tmr_q <= '0;
    else if (tmr_q != '0)     tmr_q <= tmr_q - TMR_ONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) req_o <= 1'b0;
    else         req_o <= (req_o & ~ack_i) | (trigger & ~req_o);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          wait_q <= '0;
    else if (!waiting)                    wait_q <= '0;
    else if (wait_q != WAIT_MAX)          wait_q <= wait_q + WAIT_ONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rand_o        <= '0;
      rand_valid_o  <= 1'b0;
      timeout_err_o <= 1'b0;
    end else begin
      rand_valid_o  <= handshake;
      timeout_err_o <= waiting & limit_hit;
      if (handshake) rand_o <= data_i;
    end
  end

endmodule

// File: rtl/entropy_refresh_ctrl_chk.sv
module entropy_refresh_ctrl_chk #(
  parameter int TIMER_W = 16,
  parameter int DATA_W  = 32,
  parameter int WAIT_W  = 16
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               start_i,
  input logic               done_i,
  input logic [TIMER_W-1:0] timer_load_i,
  input logic               timer_en_i,
  input logic [WAIT_W-1:0]  wait_limit_i,
  input logic               req_o,
  input logic               ack_i,
  input logic [DATA_W-1:0]  data_i,
  input logic [DATA_W-1:0]  rand_o,
  input logic               rand_valid_o,
  input logic               timeout_err_o
);

  p_req_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o && !ack_i |=> req_o);

  p_start_req_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !req_o |=> req_o);

  p_done_req_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i && !req_o |=> req_o);

  p_quiet_timer_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!timer_en_i || timer_load_i == '0) && !start_i && !done_i && !req_o |=> !req_o);

  p_ack_drops_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o && ack_i |=> !req_o);

  p_capture_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o && ack_i |=> rand_valid_o && rand_o == $past(data_i));

  p_valid_once_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rand_valid_o |=> !rand_valid_o);

  p_err_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_err_o |=> !timeout_err_o);

  p_err_pending_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_err_o |-> req_o && wait_limit_i != '0);

  p_stray_ack_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i && !req_o |=> !rand_valid_o && $stable(rand_o));

endmodule

bind entropy_refresh_ctrl entropy_refresh_ctrl_chk #(
  .TIMER_W(TIMER_W), .DATA_W(DATA_W), .WAIT_W(WAIT_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .done_i(done_i),
  .timer_load_i(timer_load_i), .timer_en_i(timer_en_i), .wait_limit_i(wait_limit_i),
  .req_o(req_o), .ack_i(ack_i), .data_i(data_i), .rand_o(rand_o),
  .rand_valid_o(rand_valid_o), .timeout_err_o(timeout_err_o)
);

// File: tb/entropy_refresh_ctrl_test.sv
module entropy_refresh_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, done = 1'b0, ack = 1'b0, tmr_en = 1'b0;
  logic [15:0] tmr_load = '0, wlim = '0;
  logic [31:0] data = '0;
  logic        req, vld, err;
  logic [31:0] rnd;
  int total = 0, bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  entropy_refresh_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .done_i(done),
    .timer_load_i(tmr_load), .timer_en_i(tmr_en), .wait_limit_i(wlim),
    .req_o(req), .ack_i(ack), .data_i(data), .rand_o(rnd),
    .rand_valid_o(vld), .timeout_err_o(err)
  );

  // {start, done, ack, data, exp_req, exp_valid, exp_rand}
  localparam int NV = 12;
  localparam logic [68:0] TBL [NV] = '{
    {3'b100, 32'h0,         2'b10, 32'h0},          // R2 start
    {3'b000, 32'h0,         2'b10, 32'h0},          // R2 hold
    {3'b010, 32'h0,         2'b10, 32'h0},          // R6 merge done
    {3'b001, 32'hA5A5_0001, 2'b01, 32'hA5A5_0001},  // R7 capture
    {3'b000, 32'h0,         2'b00, 32'hA5A5_0001},  // R7 one-cycle valid
    {3'b001, 32'h0000_1111, 2'b00, 32'hA5A5_0001},  // R10 stray ack
    {3'b010, 32'h0,         2'b10, 32'hA5A5_0001},  // R3 done
    {3'b100, 32'h0,         2'b10, 32'hA5A5_0001},  // R6 merge start
    {3'b011, 32'h0000_BEEF, 2'b01, 32'h0000_BEEF},  // R6 event on handshake
    {3'b000, 32'h0,         2'b00, 32'h0000_BEEF},  // R6 no extra request
    {3'b110, 32'h0,         2'b10, 32'h0000_BEEF},  // R2 R3 together
    {3'b001, 32'h0000_1234, 2'b01, 32'h0000_1234}   // R7
  };

  task automatic check(input string req_id, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req_id, what, act, exp);
    end
  endtask

  task automatic idle();
    start = 0; done = 0; ack = 0;
  endtask

  // one handshake: start, then ack on the next cycle; ends at the negedge after the ack edge
  task automatic fetch(input logic [31:0] d);
    start = 1; @(negedge clk); start = 0; ack = 1; data = d; @(negedge clk); ack = 0;
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int seen;
    repeat (3) @(negedge clk);
    check("R1", "req in reset", {31'b0, req}, 0);
    check("R1", "valid in reset", {31'b0, vld}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "req after reset", {31'b0, req}, 0);
    check("R1", "err after reset", {31'b0, err}, 0);
    check("R1", "rand after reset", rnd, 0);

    for (int i = 0; i < NV; i++) begin
      {start, done, ack, data} = TBL[i][68:34];
      @(negedge clk);
      check("R2/R3/R6/R7/R10", $sformatf("vec %0d req", i), {31'b0, req}, {31'b0, TBL[i][33]});
      check("R7/R10", $sformatf("vec %0d valid", i), {31'b0, vld}, {31'b0, TBL[i][32]});
      check("R7/R10", $sformatf("vec %0d rand", i), rnd, TBL[i][31:0]);
    end
    idle();
    @(negedge clk);

    // R4: period 5
    tmr_en = 1; tmr_load = 16'd5;
    fetch(32'h1);
    for (int k = 1; k <= 5; k++) begin
      @(negedge clk);
      check("R4", $sformatf("period5 cycle %0d", k), {31'b0, req}, {31'b0, k == 5});
    end
    ack = 1; @(negedge clk); ack = 0;
    for (int k = 1; k <= 5; k++) begin
      @(negedge clk);
      check("R4", $sformatf("period5 repeat cycle %0d", k), {31'b0, req}, {31'b0, k == 5});
    end
    // R4: period 1
    tmr_load = 16'd1;
    ack = 1; @(negedge clk); ack = 0;
    @(negedge clk);
    check("R4", "period1 request", {31'b0, req}, 1);
    ack = 1; @(negedge clk); ack = 0;

    // R5: zero load with enable
    tmr_load = 16'd0;
    @(negedge clk);
    fetch(32'h2);
    seen = 0;
    for (int k = 0; k < 40; k++) begin @(negedge clk); seen += req; end
    check("R5", "zero load requests", seen, 0);
    // R5: enable low
    tmr_en = 0; tmr_load = 16'd5;
    fetch(32'h3);
    seen = 0;
    for (int k = 0; k < 40; k++) begin @(negedge clk); seen += req; end
    check("R5", "disabled requests", seen, 0);

    // R9: reset mid-count
    tmr_en = 1; tmr_load = 16'd8;
    fetch(32'h4);
    repeat (3) @(negedge clk);
    rst_n = 0; repeat (2) @(negedge clk); rst_n = 1;
    check("R9", "rand cleared", rnd, 0);
    seen = 0;
    for (int k = 0; k < 30; k++) begin @(negedge clk); seen += req; end
    check("R9", "requests after reset", seen, 0);
    tmr_en = 0; tmr_load = 0;

    // R8: limit 4
    wlim = 16'd4;
    start = 1; @(negedge clk); start = 0;
    for (int k = 1; k <= 5; k++) begin
      @(negedge clk);
      check("R8", $sformatf("timeout cycle %0d", k), {31'b0, err}, {31'b0, k == 4});
    end
    check("R8", "still pending", {31'b0, req}, 1);
    ack = 1; @(negedge clk); ack = 0;
    // R8: limit 0
    wlim = 16'd0;
    start = 1; @(negedge clk); start = 0;
    seen = 0;
    for (int k = 0; k < 30; k++) begin @(negedge clk); seen += err; end
    check("R8", "errors with limit 0", seen, 0);
    ack = 1; @(negedge clk); ack = 0;
    @(negedge clk);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule